// File: doc/BRIEF.md
# Triggered-Commit Multi-Channel PWM

This block generates several independent pulse-width-modulated outputs from one input clock. Software programs each channel through a small register port. The port holds a shared control word, a shared divider word, and a period register and a high-count register for each channel. All timing values written through the port are staging values only. A channel's waveform changes only when that channel's trigger bit goes from 0 to 1. At that moment the staging values are copied into a pending snapshot. The snapshot then becomes the active setting either after a short fixed latency or at the next period boundary. The channel's smooth bit selects which of the two.

The block has no enable bit. A channel is switched off by committing a high count of zero, which gives a steady inactive level. When a channel's trigger and smooth bits are both 0, its output is forced high, whatever is committed. Each channel has a three-state commit machine: `CH_RUN`, `CH_WAIT_LAT` and `CH_WAIT_EDGE`. The transitions are:

- `CH_RUN` moves on a trigger rise. It goes to `CH_WAIT_LAT` if smooth is 0, or to `CH_WAIT_EDGE` if smooth is 1.
- `CH_WAIT_LAT` returns to `CH_RUN` when its latency counter has expired ("apply-now").
- `CH_WAIT_EDGE` returns to `CH_RUN` on a period boundary ("apply-at-boundary").
- A trigger rise in either waiting state takes priority. It re-captures the staging values and re-enters the waiting state that matches the new smooth value, dropping the older snapshot.

Top module: `pwm_trig_top`

## Requirements
- R1: After reset, every register reads 0, every `pad_push_pull` bit is 0 and every `pwm_out` bit is 1.
- R2: Register layout, byte addresses:
  - Control word at 0x00: trigger of channel c at bit c, polarity at bit 8+c, output type at bit 16+c, smooth at bit 24+c.
  - Divider word at 0x04: 3-bit divider of channel c at bits 4c+2..4c.
  - Period of channel c at 0x08+8c and high count at 0x0C+8c, 24 bits each.
  - Unused bits read 0.
- R3: Writes to the divider, period, high count or polarity do not change `pwm_out` until that channel's trigger bit rises.
- R4: The control write that raises a trigger bit with smooth 0 lands at clock edge W. The new settings drive the output from edge W+1+APPLY_LAT onward, and the counters restart at that edge. Before that edge, the old waveform continues.
- R5: A trigger rise with smooth 1 applies the new settings at the first period boundary after the capture edge W+1. The old waveform finishes its period unchanged.
- R6: With divider p, period P (P ≥ 2) and high count D, cycle k after the apply edge is active when floor(k/(p+1)) mod P < D. The output period is therefore (p+1)·P clocks.
- R7: Polarity 1 drives 1 while active and 0 while inactive. Polarity 0 inverts the output.
- R8: While a channel's trigger and smooth bits are both 0, its output is 1. In every other combination, the committed waveform drives it. The change is visible in the cycle right after the control write.
- R9: A committed high count of 0 gives a constant inactive level: 0 for polarity 1 and 1 for polarity 0.
- R10: A high count ≥ the period gives a constant active level. A period below 2 behaves as 2.
- R11: The values applied are those held in staging at the capture edge. Staging writes after that edge, including one landing on the same edge as the boundary apply, are not applied.
- R12: The output-type bits drive `pad_push_pull` directly, in the cycle after the write, with no trigger needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pwm_out | output | NCH | One PWM output per channel |
| pad_push_pull | output | NCH | Output-type bit per channel for the pad driver |

## Verification
The hazardous coincidence is a boundary apply of a smooth commit landing on the same clock edge as a software write to that channel's staging registers. The bench first aligns itself to the running waveform's phase. It then issues a smooth commit and computes the boundary edge from the old divider and period. Next it writes a different high count timed to land exactly on that edge. The output is compared cycle by cycle against a model of the snapshot values, across the boundary and for a full period afterwards. Any sign of the late write is a failure.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int CNT_W = 24;
    localparam int DIV_W = 3;

    localparam int CTL_POL_BIT  = 8;
    localparam int CTL_TYPE_BIT = 16;
    localparam int CTL_SMTH_BIT = 24;

    localparam int ADR_CTL  = 'h00;
    localparam int ADR_DIV  = 'h04;
    localparam int ADR_PER0 = 'h08;
    localparam int ADR_HI0  = 'h0C;
    localparam int ADR_STEP = 8;

    typedef enum logic [1:0] {
        CH_RUN       = 2'd0,
        CH_WAIT_LAT  = 2'd1,
        CH_WAIT_EDGE = 2'd2
    } ch_state_e;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] hi;
        logic             pol;
    } ch_cfg_t;
endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
    import pwm_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [NCH-1:0]    trig,
    output logic [NCH-1:0]    smooth,
    output logic [NCH-1:0]    otype,
    output ch_cfg_t           stage [NCH]
);
    logic [NCH-1:0]   pol_q;
    logic [DIV_W-1:0] div_q [NCH];
    logic [CNT_W-1:0] per_q [NCH];
    logic [CNT_W-1:0] hi_q  [NCH];

    wire wr_ctl = we && (addr == ADDR_W'(ADR_CTL));
    wire wr_div = we && (addr == ADDR_W'(ADR_DIV));

    // shared control and divider words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig   <= '0;
            smooth <= '0;
            otype  <= '0;
            pol_q  <= '0;
            for (int c = 0; c < NCH; c++) div_q[c] <= '0;
        end else begin
            if (wr_ctl) begin
                for (int c = 0; c < NCH; c++) begin
                    trig[c]   <= wdata[c];
                    pol_q[c]  <= wdata[CTL_POL_BIT + c];
                    otype[c]  <= wdata[CTL_TYPE_BIT + c];
                    smooth[c] <= wdata[CTL_SMTH_BIT + c];
                end
            end
            if (wr_div) begin
                for (int c = 0; c < NCH; c++) div_q[c] <= wdata[4*c +: DIV_W];
            end
        end
    end

    // per-channel count registers
    for (genvar c = 0; c < NCH; c++) begin : g_cnt_regs
        localparam int PER_ADR = ADR_PER0 + ADR_STEP * c;
        localparam int HI_ADR  = ADR_HI0 + ADR_STEP * c;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                per_q[c] <= '0;
                hi_q[c]  <= '0;
            end else if (we) begin
                if (addr == ADDR_W'(PER_ADR)) per_q[c] <= wdata[CNT_W-1:0];
                if (addr == ADDR_W'(HI_ADR))  hi_q[c]  <= wdata[CNT_W-1:0];
            end
        end
        assign stage[c] = '{div: div_q[c], per: per_q[c], hi: hi_q[c], pol: pol_q[c]};
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(ADR_CTL)) begin
            for (int c = 0; c < NCH; c++) begin
                rdata[c]                = trig[c];
                rdata[CTL_POL_BIT + c]  = pol_q[c];
                rdata[CTL_TYPE_BIT + c] = otype[c];
                rdata[CTL_SMTH_BIT + c] = smooth[c];
            end
        end else if (addr == ADDR_W'(ADR_DIV)) begin
            for (int c = 0; c < NCH; c++) rdata[4*c +: DIV_W] = div_q[c];
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (addr == ADDR_W'(ADR_PER0 + ADR_STEP * c)) rdata[CNT_W-1:0] = per_q[c];
                if (addr == ADDR_W'(ADR_HI0 + ADR_STEP * c))  rdata[CNT_W-1:0] = hi_q[c];
            end
        end
    end
endmodule

// File: rtl/pwm_wave.sv
module pwm_wave
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    input  logic [CNT_W-1:0] per,
    input  logic [CNT_W-1:0] hi,
    output logic             active,
    output logic             boundary
);
    logic [DIV_W-1:0] div_cnt;
    logic [CNT_W-1:0] per_cnt;
    logic [CNT_W-1:0] last_idx;
    logic             tick;

    // a period below 2 behaves as 2
    assign last_idx = (per < CNT_W'(2)) ? CNT_W'(1) : per - CNT_W'(1);
    assign tick     = (div_cnt == div);
    assign boundary = tick && (per_cnt >= last_idx);
    assign active   = (per_cnt < hi);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
            per_cnt <= '0;
        end else if (restart) begin
            div_cnt <= '0;
            per_cnt <= '0;
        end else begin
            div_cnt <= tick ? '0 : div_cnt + DIV_W'(1);
            if (tick) per_cnt <= (per_cnt >= last_idx) ? '0 : per_cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/pwm_chan_ctl.sv
module pwm_chan_ctl
    import pwm_pkg::*;
#(
    parameter int APPLY_LAT = 1
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    trig_i,
    input  logic    smooth_i,
    input  ch_cfg_t stage_i,
    output logic    pwm_o
);
    localparam int LAT_W = (APPLY_LAT < 2) ? 1 : $clog2(APPLY_LAT);

    ch_state_e  state, state_d;
    ch_cfg_t    pend, act;
    logic       trig_q, rise, capture, apply;
    logic [LAT_W-1:0] lat_cnt;
    logic       active, boundary;

    assign rise = trig_i && !trig_q;

    // next-state decision
    always_comb begin
        state_d = state;
        capture = 1'b0;
        apply   = 1'b0;
        if (rise) begin
            capture = 1'b1;
            state_d = smooth_i ? CH_WAIT_EDGE : CH_WAIT_LAT;
        end else begin
            unique case (state)
                CH_RUN: state_d = CH_RUN;
                CH_WAIT_LAT: begin
                    if (lat_cnt == '0) begin
                        apply   = 1'b1;
                        state_d = CH_RUN;
                    end
                end
                CH_WAIT_EDGE: begin
                    if (boundary) begin
                        apply   = 1'b1;
                        state_d = CH_RUN;
                    end
                end
                default: state_d = CH_RUN;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CH_RUN;
        else        state <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_q  <= 1'b0;
            pend    <= '0;
            act     <= '0;
            lat_cnt <= '0;
        end else begin
            trig_q <= trig_i;
            if (capture) begin
                pend    <= stage_i;
                lat_cnt <= LAT_W'(APPLY_LAT - 1);
            end else if (state == CH_WAIT_LAT && lat_cnt != '0) begin
                lat_cnt <= lat_cnt - LAT_W'(1);
            end
            if (apply) act <= pend;
        end
    end

    pwm_wave u_wave (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (apply),
        .div      (act.div),
        .per      (act.per),
        .hi       (act.hi),
        .active   (active),
        .boundary (boundary)
    );

    // output process
    always_comb begin
        if (!trig_i && !smooth_i) pwm_o = 1'b1;
        else                      pwm_o = act.pol ? active : !active;
    end
endmodule

// File: rtl/pwm_trig_top.sv
module pwm_trig_top
    import pwm_pkg::*;
#(
    parameter int NCH       = 2,
    parameter int ADDR_W    = 8,
    parameter int APPLY_LAT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NCH-1:0]    pwm_out,
    output logic [NCH-1:0]    pad_push_pull
);
    logic [NCH-1:0] trig, smooth, otype;
    ch_cfg_t        stage [NCH];

    pwm_regfile #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (bus_we),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .rdata  (bus_rdata),
        .trig   (trig),
        .smooth (smooth),
        .otype  (otype),
        .stage  (stage)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pwm_chan_ctl #(.APPLY_LAT(APPLY_LAT)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .trig_i   (trig[c]),
            .smooth_i (smooth[c]),
            .stage_i  (stage[c]),
            .pwm_o    (pwm_out[c])
        );
    end

    assign pad_push_pull = otype;
endmodule

// File: rtl/pwm_chan_checker.sv
module pwm_chan_checker
    import pwm_pkg::*;
#(
    parameter int LAT_W = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trig_i,
    input logic             smooth_i,
    input logic             rise,
    input ch_state_e        state,
    input logic [LAT_W-1:0] lat_cnt,
    input logic             boundary,
    input ch_cfg_t          act,
    input logic             pwm_o
);
    p_force_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_i && !smooth_i) |-> pwm_o);

    p_hold_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_RUN && !rise) |=> $stable(act));

    p_wait_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_WAIT_EDGE && !rise && !boundary) |=> (state == CH_WAIT_EDGE && $stable(act)));

    p_lat_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_WAIT_LAT && lat_cnt == '0 && !rise) |=> (state == CH_RUN));

    p_zero_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (act.hi == '0 && (trig_i || smooth_i)) |-> (pwm_o == !act.pol));

    p_full_hi_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (act.per >= CNT_W'(2) && act.hi >= act.per && (trig_i || smooth_i)) |-> (pwm_o == act.pol));
endmodule

bind pwm_chan_ctl pwm_chan_checker #(.LAT_W(LAT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_i   (trig_i),
    .smooth_i (smooth_i),
    .rise     (rise),
    .state    (state),
    .lat_cnt  (lat_cnt),
    .boundary (boundary),
    .act      (act),
    .pwm_o    (pwm_o)
);

// File: tb/tb_pwm_trig_top.sv
module tb_pwm_trig_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 2;
    localparam int LAT = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NCH-1:0] pwm_out, pad_push_pull;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;
    logic [31:0] ctl = '0, divw = '0;

    // model: old and new committed settings per channel
    int o_div[NCH], o_per[NCH], o_hi[NCH], o_pol[NCH], o_a[NCH];
    int n_div[NCH], n_per[NCH], n_hi[NCH], n_pol[NCH], n_a[NCH];

    pwm_trig_top #(.NCH(NCH), .ADDR_W(8), .APPLY_LAT(LAT)) dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_out(pwm_out), .pad_push_pull(pad_push_pull)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h cycle=%0d", req, act, exp, cyc);
        end
    endtask

    function automatic int model_out(int ch, int c);
        int dv, pr, hi, pl, a, k, effp, actv;
        if (!ctl[ch] && !ctl[24+ch]) return 1;
        if (c >= n_a[ch]) begin dv = n_div[ch]; pr = n_per[ch]; hi = n_hi[ch]; pl = n_pol[ch]; a = n_a[ch]; end
        else begin dv = o_div[ch]; pr = o_per[ch]; hi = o_hi[ch]; pl = o_pol[ch]; a = o_a[ch]; end
        effp = (pr < 2) ? 2 : pr;
        k = c - a;
        actv = (((k / (dv + 1)) % effp) < hi) ? 1 : 0;
        return pl ? actv : 1 - actv;
    endfunction

    task automatic wr(int addr, logic [31:0] data);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 8'(addr); bus_wdata = data;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(string req, int addr, logic [31:0] exp);
        @(negedge clk);
        bus_addr = 8'(addr);
        #1 check(req, int'(bus_rdata), int'(exp));
    endtask

    task automatic stage_vals(int ch, int dv, int pr, int hi, int pl);
        ctl[ch] = 1'b0; ctl[24+ch] = 1'b1;
        wr(0, ctl);
        divw[4*ch +: 3] = 3'(dv);
        wr(4, divw);
        wr(8 + 8*ch, pr);
        wr(12 + 8*ch, hi);
        ctl[8+ch] = 1'(pl);
    endtask

    task automatic shift_model(int ch, int dv, int pr, int hi, int pl, int a);
        o_div[ch] = n_div[ch]; o_per[ch] = n_per[ch]; o_hi[ch] = n_hi[ch];
        o_pol[ch] = n_pol[ch]; o_a[ch] = n_a[ch];
        n_div[ch] = dv; n_per[ch] = pr; n_hi[ch] = hi; n_pol[ch] = pl; n_a[ch] = a;
    endtask

    task automatic commit_now(int ch, int dv, int pr, int hi, int pl);
        stage_vals(ch, dv, pr, hi, pl);
        ctl[ch] = 1'b1; ctl[24+ch] = 1'b0;
        wr(0, ctl);
        shift_model(ch, dv, pr, hi, pl, cyc + 1 + LAT);
    endtask

    task automatic check_wave(string req, int ch, int n);
        for (int i = 0; i < n; i++) begin
            check(req, int'(pwm_out[ch]), model_out(ch, cyc));
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        check("R1 pwm_out", int'(pwm_out), 3);
        check("R1 pad_push_pull", int'(pad_push_pull), 0);
        for (int a = 0; a < 24; a += 4) rd_chk("R1 reg", a, 32'h0);
    endtask

    task automatic t_regs;
        ctl[17] = 1'b1;
        wr(0, ctl);
        check("R12 pad type", int'(pad_push_pull), 2);
        rd_chk("R2 ctl", 0, 32'h0002_0000);
        wr(4, 32'h0000_0050);
        rd_chk("R2 div", 4, 32'h0000_0050);
        divw = 32'h50;
        wr(16, 32'hFFAB_CDEF);
        rd_chk("R2 per1", 16, 32'h00AB_CDEF);
        wr(20, 32'h0012_3456);
        rd_chk("R2 hi1", 20, 32'h0012_3456);
        wr(12, 32'h7);
        rd_chk("R2 hi0", 12, 32'h7);
        ctl[17] = 1'b0;
        wr(0, ctl);
        check("R12 pad clear", int'(pad_push_pull), 0);
    endtask

    task automatic t_stage_hold;
        commit_now(0, 0, 4, 0, 1);
        check_wave("R9 steady low", 0, 8);
        stage_vals(0, 0, 4, 2, 0);
        check_wave("R3 staged no effect", 0, 10);
    endtask

    task automatic t_latency;
        int w;
        stage_vals(0, 0, 4, 9, 1);
        ctl[0] = 1'b1; ctl[24] = 1'b0;
        wr(0, ctl);
        w = cyc;
        shift_model(0, 0, 4, 9, 1, w + 1 + LAT);
        @(negedge clk);
        check("R4 old kept before apply", int'(pwm_out[0]), 0);
        @(negedge clk);
        check("R4 new at apply edge", int'(pwm_out[0]), 1);
        check_wave("R10 full duty", 0, 10);
    endtask

    task automatic t_force;
        commit_now(0, 0, 5, 0, 1);
        check_wave("R9 low before force", 0, 6);
        ctl[0] = 1'b0; ctl[24] = 1'b0;
        wr(0, ctl);
        check_wave("R8 forced high", 0, 5);
        ctl[24] = 1'b1;
        wr(0, ctl);
        check_wave("R8 waveform resumes", 0, 5);
        check("R8 low after release", int'(pwm_out[0]), 0);
    endtask

    task automatic t_wave;
        commit_now(1, 2, 5, 2, 1);
        check_wave("R6 divided wave", 1, 40);
        commit_now(1, 0, 8, 3, 0);
        check_wave("R7 inverted wave", 1, 24);
    endtask

    task automatic t_zero_full;
        commit_now(1, 0, 6, 0, 1);
        check_wave("R9 zero duty pol1", 1, 15);
        commit_now(1, 0, 6, 0, 0);
        check_wave("R9 zero duty pol0", 1, 15);
        commit_now(0, 0, 6, 50, 1);
        check_wave("R10 duty above period", 0, 15);
        commit_now(0, 1, 1, 1, 1);
        check_wave("R10 period below two", 0, 16);
    endtask

    task automatic t_smooth;
        int l, c, m, na;
        commit_now(1, 0, 40, 10, 1);
        check_wave("R6 long wave", 1, 45);
        l = 40;
        while (((cyc - n_a[1]) % l) != 2) @(negedge clk);
        stage_vals(1, 1, 6, 2, 1);
        ctl[1] = 1'b1; ctl[25] = 1'b1;
        wr(0, ctl);
        c = cyc + 1;
        m = (c - n_a[1]) / l + 1;
        na = n_a[1] + m * l;
        shift_model(1, 1, 6, 2, 1, na);
        wr(12 + 8, 32'd5);
        while (cyc < na - 1) begin
            check("R5 old period completes", int'(pwm_out[1]), model_out(1, cyc));
            @(negedge clk);
        end
        bus_we = 1'b1; bus_addr = 8'(20); bus_wdata = 32'd11;
        check("R5 before boundary", int'(pwm_out[1]), model_out(1, cyc));
        @(negedge clk);
        bus_we = 1'b0;
        check_wave("R11 snapshot at boundary", 1, 30);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            o_div[c] = 0; o_per[c] = 0; o_hi[c] = 0; o_pol[c] = 0; o_a[c] = 0;
            n_div[c] = 0; n_per[c] = 0; n_hi[c] = 0; n_pol[c] = 0; n_a[c] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_stage_hold();
        t_latency();
        t_force();
        t_wave();
        t_zero_full();
        t_smooth();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule